// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer for a processor subsystem. It holds a timeout counter that is advanced through a fixed clock divider and a selectable prescaler. Software arms the watchdog, and keeps it from expiring, by writing a two-byte key to the key register: 1Eh, then E1h. If the count expires before the next complete key, the block raises its reset output for a fixed number of clock cycles. A key whose second byte is wrong raises the same reset at once.

The prescale code sits in a control register that software writes ahead of the key. The written code stays in a shadow register. The code that is read back and used for timing changes only when a complete key arrives. After power-on reset the watchdog is idle. Once armed it cannot be stopped by any write. Only the reset input, an expiry or a wrong key returns it to the idle state.

Top module: `wdog_top`

## Requirements
- R1: After `rst_ni` is released, `wdt_rst_o` is low and `ctrl_rdata_o` reads 0. The watchdog is disarmed and never expires until it has been armed. Pulling `rst_ni` low at any time disarms it and clears the control register.
- R2: A key-register write (`wr_addr_i`=0) of 1Eh, followed by the next key-register write of E1h, arms the watchdog. Writes to the control register between the two bytes do not break the key. The reset output then rises after exactly (2^CNT_W−1)·F·DIV clock edges, counted from the E1h write edge, where F is the active prescale factor.
- R3: The 3-bit prescale codes 0 to 7 select F = 1, 4, 16, 64, 128, 256, 512 and 1024.
- R4: A complete key written while the watchdog is armed restarts the count from zero, so the next expiry is measured from the latest E1h write.
- R5: When a key-register write follows a pending 1Eh and its value is not E1h (1Eh included), `wdt_rst_o` goes high on the very next cycle.
- R6: A key-register write that is not 1Eh, made while no 1Eh is pending, has no effect. A lone E1h does not arm the watchdog.
- R7: Once the watchdog is armed, no write disarms it. Neither stray key values nor control writes stop the count.
- R8: Each reset pulse lasts exactly PULSE_W cycles (default 98).
- R9: A control-register write (`wr_addr_i`=1, bits 2:0) goes only to the shadow register. `ctrl_rdata_o` and the prescale factor in use keep the previous code until the next complete key loads the shadow.
- R10: Both an expiry and a wrong key disarm the watchdog, clear its counters and drop any pending 1Eh. Key-register writes made while the reset pulse is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Register select: 0 = key register, 1 = control register |
| wr_data_i | input | 8 | Write data |
| ctrl_rdata_o | output | 3 | Active prescale code (read value of the control register) |
| wdt_rst_o | output | 1 | Watchdog reset pulse, active high |

## Verification
The expiry is timed for prescale codes 0, 1, 2, 3, 4 and 7. This shows whether the factor table and the fixed divide-by-DIV stage are both in the path, with none off by one cycle. Several key patterns are applied: a correct key, a wrong second byte, a repeated 1Eh, a lone E1h and stray values. These separate the arming path, the immediate-reset path and the ignore path. Repeated refreshes just before expiry, and key writes made during the reset pulse, show whether the count truly restarts and whether the pulse blocks the key logic. A cycle-by-cycle behavioural model checks both outputs on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [7:0] KEY_ARM     = 8'h1E;
  localparam logic [7:0] KEY_CONFIRM = 8'hE1;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned PRE_W      = 10;

  typedef enum logic {
    REG_KEY  = 1'b0,
    REG_CTRL = 1'b1
  } reg_sel_e;

  // prescale factor minus one: codes 0..3 -> 4^code, codes 4..7 -> 128 << (code-4)
  function automatic logic [PRE_W-1:0] presc_last(input logic [SEL_W-1:0] code);
    logic [PRE_W:0] f;
    if (code < 3'd4) f = (PRE_W+1)'(1) << (2 * code);
    else             f = (PRE_W+1)'(128) << (code - 3'd4);
    return PRE_W'(f - 1'b1);
  endfunction

endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             block_i,
  input  logic             clr_i,
  output logic             refresh_o,
  output logic             bad_key_o,
  output logic [SEL_W-1:0] ctrl_act_o
);

  logic             pend_q;
  logic [SEL_W-1:0] shadow_q;
  logic             key_wr, ctrl_wr;

  assign key_wr  = wr_en_i & (wr_addr_i == REG_KEY) & ~block_i;
  assign ctrl_wr = wr_en_i & (wr_addr_i == REG_CTRL);

  assign refresh_o = key_wr & pend_q & (wr_data_i == KEY_CONFIRM);
  assign bad_key_o = key_wr & pend_q & (wr_data_i != KEY_CONFIRM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (clr_i) begin
      pend_q <= 1'b0;
    end else if (key_wr) begin
      pend_q <= ~pend_q & (wr_data_i == KEY_ARM);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q   <= '0;
      ctrl_act_o <= '0;
    end else begin
      if (ctrl_wr)   shadow_q   <= wr_data_i[SEL_W-1:0];
      if (refresh_o) ctrl_act_o <= shadow_q;
    end
  end

  // R9: active code only moves on a complete key
  p_ctrl_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !refresh_o |=> $stable(ctrl_act_o));

  // R6: stray value with nothing pending leaves no pending state
  p_stray_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && !pend_q && wr_data_i != KEY_ARM) |=> !pend_q);

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
#(
  parameter int unsigned DIV = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] code_i,
  output logic             tick_o
);

  localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_last;
  logic             div_wrap;

  assign pre_last = presc_last(code_i);
  assign div_wrap = run_i & (div_q == DIV_LAST);
  assign tick_o   = div_wrap & (pre_q == pre_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      pre_q <= '0;
    end else if (clr_i || !run_i) begin
      div_q <= '0;
      pre_q <= '0;
    end else begin
      div_q <= div_wrap ? '0 : div_q + 1'b1;
      if (div_wrap) pre_q <= tick_o ? '0 : pre_q + 1'b1;
    end
  end

  // R3: prescale count never passes the selected factor
  p_pre_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= pre_last);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic expire_o
);

  // expiry after (2^CNT_W - 1) ticks
  localparam logic [CNT_W-1:0] CNT_TERM = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i & tick_i & (cnt_q == CNT_TERM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || !run_i)   cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + 1'b1;
  end

  // R2: count stops one short of all-ones
  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_TERM);

  // R1: an idle counter never expires
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !expire_o);

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned PULSE_W = 98
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic active_o
);

  localparam int unsigned PW = $clog2(PULSE_W + 1);

  logic [PW-1:0] left_q;
  logic [PW-1:0] run_q;

  assign active_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       left_q <= '0;
    else if (fire_i)   left_q <= PW'(PULSE_W);
    else if (active_o) left_q <= left_q - 1'b1;
  end

  // length of the current high run, for the width check
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= '0;
    else if (active_o) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  p_pulse_width_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> (run_q == PW'(PULSE_W)));

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned DIV     = 6,
  parameter int unsigned PULSE_W = 98
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [7:0]       wr_data_i,
  output logic [SEL_W-1:0] ctrl_rdata_o,
  output logic             wdt_rst_o
);

  logic armed_q;
  logic refresh, bad_key, tick, expire, fire, clr;

  // refresh wins over an expiry on the same edge
  assign fire = bad_key | (expire & ~refresh);
  assign clr  = refresh | fire;

  wdog_unlock u_unlock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .block_i    (wdt_rst_o),
    .clr_i      (fire),
    .refresh_o  (refresh),
    .bad_key_o  (bad_key),
    .ctrl_act_o (ctrl_rdata_o)
  );

  wdog_prescaler #(.DIV(DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (armed_q),
    .clr_i  (clr),
    .code_i (ctrl_rdata_o),
    .tick_o (tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (armed_q),
    .clr_i    (clr),
    .tick_i   (tick),
    .expire_o (expire)
  );

  wdog_pulse #(.PULSE_W(PULSE_W)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .active_o (wdt_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (fire)    armed_q <= 1'b0;
    else if (refresh) armed_q <= 1'b1;
  end

  // R5: wrong second byte raises reset on the next cycle
  p_bad_key_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_key |=> wdt_rst_o);

  // R10: any firing leaves the watchdog idle
  p_disarm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !armed_q);

  // R7: armed state only ends through a firing
  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !fire) |=> armed_q);

  // R10: no new firing while a pulse is still out
  p_no_refire_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> !fire);

endmodule

// File: tb/wdog_top_tb.sv
`timescale 1ns/100ps
module wdog_top_tb;

  localparam int CNT_W   = 4;
  localparam int DIV     = 6;
  localparam int PULSE_W = 98;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       wr_addr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] ctrl_rdata_o;
  logic       wdt_rst_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  wdog_top #(.CNT_W(CNT_W), .DIV(DIV), .PULSE_W(PULSE_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .ctrl_rdata_o(ctrl_rdata_o), .wdt_rst_o(wdt_rst_o)
  );

  function automatic int factor(input int code);
    case (code)
      0: return 1;    1: return 4;    2: return 16;   3: return 64;
      4: return 128;  5: return 256;  6: return 512;  default: return 1024;
    endcase
  endfunction

  function automatic int limit(input int code);
    return ((1 << CNT_W) - 1) * factor(code) * DIV;
  endfunction

  // behavioural reference model
  int m_armed, m_pend, m_shadow, m_act, m_elapsed, m_pulse;
  int m_busy, m_fire, m_refr;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_armed = 0; m_pend = 0; m_shadow = 0; m_act = 0; m_elapsed = 0; m_pulse = 0;
    end else begin
      m_busy = (m_pulse > 0);
      m_fire = 0;
      m_refr = 0;
      if (m_pulse > 0) m_pulse = m_pulse - 1;
      if (wr_en_i && wr_addr_i) m_shadow = int'(wr_data_i[2:0]);
      if (wr_en_i && !wr_addr_i && !m_busy) begin
        if (m_pend != 0) begin
          m_pend = 0;
          if (wr_data_i == 8'hE1) m_refr = 1; else m_fire = 1;
        end else if (wr_data_i == 8'h1E) m_pend = 1;
      end
      if (m_armed != 0 && m_refr == 0) begin
        m_elapsed = m_elapsed + 1;
        if (m_elapsed == limit(m_act)) m_fire = 1;
      end
      if (m_refr != 0) begin
        m_armed = 1; m_act = m_shadow; m_elapsed = 0;
      end
      if (m_fire != 0) begin
        m_armed = 0; m_pend = 0; m_elapsed = 0; m_pulse = PULSE_W;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      checks++;
      if (wdt_rst_o !== (m_pulse > 0)) begin
        failures++;
        $display("FAIL R2 model wdt_rst_o got=%0b exp=%0b at %0t", wdt_rst_o, m_pulse > 0, $time);
      end
      checks++;
      if (int'(ctrl_rdata_o) != m_act) begin
        failures++;
        $display("FAIL R9 model ctrl_rdata_o got=%0d exp=%0d at %0t", ctrl_rdata_o, m_act, $time);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the write edge
  task automatic wr(input bit a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_addr_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic arm(input int code);
    wr(1'b1, 8'(code));
    wr(1'b0, 8'h1E);
    wr(1'b0, 8'hE1);
  endtask

  task automatic time_to_rst(output int n);
    n = 0;
    while (!wdt_rst_o && n < 120000) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic pulse_len(output int w);
    w = 0;
    while (wdt_rst_o && w < 1000) begin
      w++;
      @(negedge clk_i);
    end
  endtask

  task automatic quiet(input int cycles, input string req);
    int hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      if (wdt_rst_o) hits++;
    end
    check(hits == 0, req, hits, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n, w;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(wdt_rst_o == 1'b0, "R1 reset output", wdt_rst_o, 0);
    check(ctrl_rdata_o == 3'd0, "R1 reset ctrl", ctrl_rdata_o, 0);
    quiet(200, "R1 idle after reset");

    // R6: lone E1h and stray values
    wr(1'b0, 8'hE1);
    wr(1'b0, 8'h33);
    quiet(300, "R6 lone E1h ignored");

    // R9: shadow hidden until key; R2/R3 code 2
    wr(1'b1, 8'h02);
    check(ctrl_rdata_o == 3'd0, "R9 shadow not visible", ctrl_rdata_o, 0);
    wr(1'b0, 8'h1E);
    wr(1'b1, 8'h02);
    wr(1'b0, 8'hE1);
    check(ctrl_rdata_o == 3'd2, "R9 code applied", ctrl_rdata_o, 2);
    time_to_rst(n);
    check(n == limit(2), "R2 timeout code 2", n, limit(2));
    pulse_len(w);
    check(w == PULSE_W, "R8 pulse width", w, PULSE_W);
    quiet(2000, "R10 disarmed after expiry");

    // R4: refresh repeatedly with code 0
    arm(0);
    for (int k = 0; k < 5; k++) begin
      repeat (60) @(negedge clk_i);
      wr(1'b0, 8'h1E);
      wr(1'b0, 8'hE1);
    end
    time_to_rst(n);
    check(n == limit(0), "R4 timeout from last refresh", n, limit(0));
    pulse_len(w);

    // R7: stray key value and control write do not stop or alter count
    arm(0);
    wr(1'b0, 8'h55);
    wr(1'b1, 8'h07);
    check(ctrl_rdata_o == 3'd0, "R9 armed ctrl write hidden", ctrl_rdata_o, 0);
    time_to_rst(n);
    check(n == limit(0) - 2, "R7 still armed after writes", n, limit(0) - 2);
    pulse_len(w);

    // R5: wrong second byte, key writes during pulse ignored (R10)
    wr(1'b1, 8'h00);
    arm(0);
    wr(1'b0, 8'h1E);
    wr(1'b0, 8'h00);
    check(wdt_rst_o == 1'b1, "R5 immediate reset", wdt_rst_o, 1);
    wr(1'b0, 8'h1E);
    wr(1'b0, 8'hE1);
    pulse_len(w);
    check(w == PULSE_W - 2, "R8 remaining pulse", w, PULSE_W - 2);
    quiet(300, "R10 keys ignored during pulse");

    // R5: repeated 1Eh while idle
    wr(1'b0, 8'h1E);
    wr(1'b0, 8'h1E);
    check(wdt_rst_o == 1'b1, "R5 double 1Eh", wdt_rst_o, 1);
    pulse_len(w);
    check(w == PULSE_W, "R8 pulse width after key error", w, PULSE_W);

    // R3: more factors
    arm(1);
    time_to_rst(n);
    check(n == limit(1), "R3 code 1", n, limit(1));
    pulse_len(w);
    arm(3);
    time_to_rst(n);
    check(n == limit(3), "R3 code 3", n, limit(3));
    pulse_len(w);
    arm(4);
    time_to_rst(n);
    check(n == limit(4), "R3 code 4", n, limit(4));
    pulse_len(w);
    arm(7);
    time_to_rst(n);
    check(n == limit(7), "R3 code 7", n, limit(7));
    pulse_len(w);

    // R1: reset input disarms an armed watchdog
    arm(5);
    repeat (50) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(ctrl_rdata_o == 3'd0, "R1 ctrl cleared by reset", ctrl_rdata_o, 0);
    quiet(500, "R1 disarmed by reset");

    finish_run();
  end

endmodule